// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store of whole cache lines that sits next to a direct-mapped data cache. When the main cache replaces a line, the outgoing line is pushed into this buffer. Any entry can hold any line. When the main cache misses, the controller probes the buffer with the full block address. The answer comes back on the next clock edge. A hit returns the line, so no request goes to the lower memory level.

On a hit, the line that the main cache is about to displace from its slot goes into the buffer entry that held the hit line. The two lines trade places in one transaction. On a miss, the block raises a fetch request toward the next level. Any displaced line that came with that probe is kept as an ordinary victim.

When every entry is valid, a new line overwrites the oldest one, in insertion order. If the overwritten line is dirty, the block presents it for writeback in the same cycle, before the edge that overwrites it.

Top module: `victim_buf`

## Requirements
- R1: After reset no entry is valid. The first probe reports a miss, and `rsp_valid`, `fetch_valid` and `wb_valid` are low while idle.
- R2: A probe accepted at one rising edge produces `rsp_valid` high for exactly one cycle after that edge. `rsp_valid` is low in a cycle that follows an edge with no probe.
- R3: A probe whose `probe_addr` equals the full block address of a valid entry reports `rsp_hit`=1 and returns that entry's line on `rsp_data` and its dirty flag on `rsp_dirty`.
- R4: A probe that matches no valid entry reports `rsp_hit`=0. In the same cycle it raises `fetch_valid` with `fetch_addr` equal to the probed address.
- R5: On a hit with `disp_valid`=1, the hit entry is replaced by the displaced line. A later probe of the displaced address hits with its data and dirty flag. A later probe of the old address misses.
- R6: On a hit with `disp_valid`=0, the hit entry is freed, so a later probe of the same address misses.
- R7: With free entries, an insert (`evict_valid`) takes a free entry without any writeback. `DEPTH` distinct lines can be held at once, and all of them later hit.
- R8: An insert into a full buffer replaces the entry inserted longest ago (FIFO order).
- R9: When a replaced entry is dirty, `wb_valid` is high combinationally in the cycle of the insert, with its address and data on `wb_addr` and `wb_data`. Replacing a clean entry gives `wb_valid`=0.
- R10: An insert presented in the same cycle as a probe is ignored, so a later probe of its address misses.
- R11: On a miss with `disp_valid`=1, the displaced line is stored as a new victim under the same allocation and writeback rules as an insert.
- R12: A line placed by a swap counts as the newest entry for FIFO replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | Line evicted by the main cache is offered for storage |
| evict_addr | input | ADDR_W | Full block address of the evicted line |
| evict_dirty | input | 1 | Evicted line is modified |
| evict_data | input | LINE_W | Evicted line contents |
| probe_valid | input | 1 | Probe after a main-cache miss |
| probe_addr | input | ADDR_W | Block address being probed |
| disp_valid | input | 1 | A line will be displaced from the main-cache slot by this probe |
| disp_addr | input | ADDR_W | Block address of the displaced line |
| disp_dirty | input | 1 | Displaced line is modified |
| disp_data | input | LINE_W | Displaced line contents |
| rsp_valid | output | 1 | Probe result valid |
| rsp_hit | output | 1 | Probe found the line |
| rsp_dirty | output | 1 | Dirty flag of the returned line |
| rsp_data | output | LINE_W | Returned line toward the main cache |
| fetch_valid | output | 1 | Request to the next memory level after a miss |
| fetch_addr | output | ADDR_W | Block address to fetch |
| wb_valid | output | 1 | Dirty line being overwritten must be written back |
| wb_addr | output | ADDR_W | Block address of the writeback line |
| wb_data | output | LINE_W | Writeback line contents |

## Verification
A wrong age rank shows up the first time a full buffer takes a new line. A different line then appears on `wb_addr` in that same cycle, or a line that should have left still hits on a probe. A tag or valid bit that is wrong shows on the next probe response, one edge later, as a hit where a miss was expected or as the wrong line or dirty flag. A swap that fails to write its slot surfaces when either of the two exchanged addresses is probed again.

// File: rtl/vc_pkg.sv
`timescale 1ns/1ps
package vc_pkg;

  localparam int MAX_DEPTH = 32;

  typedef enum logic [1:0] {
    VC_IDLE,
    VC_FILL,
    VC_SWAP,
    VC_DROP
  } vc_op_e;

  // Index of the lowest set bit, zero when none is set.
  function automatic int first_set(input logic [MAX_DEPTH-1:0] v);
    int r;
    r = 0;
    for (int i = MAX_DEPTH - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Rank of an entry after another entry (old rank old_r) becomes newest.
  function automatic int rank_after_write(input int cur, input int old_r);
    return (cur < old_r) ? cur + 1 : cur;
  endfunction

  // Rank of an entry after an entry of rank gone_r is freed.
  function automatic int rank_after_free(input int cur, input int gone_r);
    return (cur > gone_r) ? cur - 1 : cur;
  endfunction

endpackage

// File: rtl/vc_match.sv
`timescale 1ns/1ps
module vc_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 28,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]             entry_valid,
  input  logic [DEPTH-1:0][ADDR_W-1:0] entry_tag,
  input  logic [ADDR_W-1:0]            key,
  output logic [DEPTH-1:0]             hit_vec,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);

  logic [vc_pkg::MAX_DEPTH-1:0] hit_wide;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = entry_valid[g] && (entry_tag[g] == key);
  end

  always_comb begin
    hit_wide = '0;
    hit_wide[DEPTH-1:0] = hit_vec;
  end

  assign hit     = |hit_vec;
  assign hit_idx = IDX_W'(vc_pkg::first_set(hit_wide));

endmodule

// File: rtl/vc_age.sv
`timescale 1ns/1ps
module vc_age #(
  parameter int DEPTH = 4,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int RANK_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] entry_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [IDX_W-1:0] oldest_idx
);

  logic [IDX_W-1:0]  rank_q [DEPTH];
  logic [RANK_W-1:0] wr_old_rank;
  logic [RANK_W-1:0] clr_rank;

  // A slot that was empty has no rank: every valid entry ages past it.
  assign wr_old_rank = entry_valid[wr_idx] ? {1'b0, rank_q[wr_idx]}
                                           : RANK_W'(DEPTH);
  assign clr_rank    = {1'b0, rank_q[clr_idx]};

  for (genvar g = 0; g < DEPTH; g++) begin : g_rank
    logic [RANK_W-1:0] cur;
    assign cur = {1'b0, rank_q[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rank_q[g] <= '0;
      end else if (wr_en) begin
        if (wr_idx == IDX_W'(g)) begin
          rank_q[g] <= '0;
        end else if (entry_valid[g]) begin
          rank_q[g] <= IDX_W'(vc_pkg::rank_after_write(int'(cur), int'(wr_old_rank)));
        end
      end else if (clr_en) begin
        if (entry_valid[g] && clr_idx != IDX_W'(g)) begin
          rank_q[g] <= IDX_W'(vc_pkg::rank_after_free(int'(cur), int'(clr_rank)));
        end
      end
    end
  end

  always_comb begin
    logic [IDX_W-1:0] best;
    best       = '0;
    oldest_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entry_valid[i] && rank_q[i] >= best) begin
        best       = rank_q[i];
        oldest_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/vc_store.sv
`timescale 1ns/1ps
module vc_store #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 28,
  parameter int LINE_W = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic                         wr_dirty,
  input  logic [LINE_W-1:0]            wr_data,
  input  logic                         clr_en,
  input  logic [IDX_W-1:0]             clr_idx,
  output logic [DEPTH-1:0]             entry_valid,
  output logic [DEPTH-1:0][ADDR_W-1:0] entry_tag,
  output logic [DEPTH-1:0]             entry_dirty,
  output logic [DEPTH-1:0][LINE_W-1:0] entry_data
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              v_q;
    logic              d_q;
    logic [ADDR_W-1:0] t_q;
    logic [LINE_W-1:0] l_q;
    logic              sel_wr;
    logic              sel_clr;

    assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(g));
    assign sel_clr = clr_en && (clr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        t_q <= '0;
        l_q <= '0;
      end else if (sel_wr) begin
        v_q <= 1'b1;
        d_q <= wr_dirty;
        t_q <= wr_addr;
        l_q <= wr_data;
      end else if (sel_clr) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end
    end

    assign entry_valid[g] = v_q;
    assign entry_dirty[g] = d_q;
    assign entry_tag[g]   = t_q;
    assign entry_data[g]  = l_q;
  end

endmodule

// File: rtl/victim_buf.sv
`timescale 1ns/1ps
module victim_buf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 28,
  parameter int LINE_W = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              evict_dirty,
  input  logic [LINE_W-1:0] evict_data,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              disp_valid,
  input  logic [ADDR_W-1:0] disp_addr,
  input  logic              disp_dirty,
  input  logic [LINE_W-1:0] disp_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_dirty,
  output logic [LINE_W-1:0] rsp_data,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);

  import vc_pkg::*;

  logic [DEPTH-1:0]             entry_valid;
  logic [DEPTH-1:0][ADDR_W-1:0] entry_tag;
  logic [DEPTH-1:0]             entry_dirty;
  logic [DEPTH-1:0][LINE_W-1:0] entry_data;

  logic [DEPTH-1:0] hit_vec;
  logic             probe_hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] oldest_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;
  logic [MAX_DEPTH-1:0] free_wide;

  // Named events for the checker.
  vc_op_e           op;
  logic             fill_from_evict;
  logic             fill_from_disp;
  logic             evict_oldest;

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [ADDR_W-1:0] wr_addr;
  logic             wr_dirty;
  logic [LINE_W-1:0] wr_data;
  logic             clr_en;

  vc_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
    .entry_valid (entry_valid),
    .entry_tag   (entry_tag),
    .key         (probe_addr),
    .hit_vec     (hit_vec),
    .hit         (probe_hit),
    .hit_idx     (hit_idx)
  );

  always_comb begin
    free_wide = '0;
    free_wide[DEPTH-1:0] = ~entry_valid;
  end
  assign any_free = ~&entry_valid;
  assign free_idx = IDX_W'(first_set(free_wide));

  // A probe owns the cycle; a concurrent insert is dropped.
  assign fill_from_evict = evict_valid && !probe_valid;
  assign fill_from_disp  = probe_valid && !probe_hit && disp_valid;

  always_comb begin
    op = VC_IDLE;
    if (probe_valid) begin
      if (probe_hit) op = disp_valid ? VC_SWAP : VC_DROP;
      else if (disp_valid) op = VC_FILL;
    end else if (evict_valid) begin
      op = VC_FILL;
    end
  end

  always_comb begin
    wr_en    = (op == VC_FILL) || (op == VC_SWAP);
    clr_en   = (op == VC_DROP);
    wr_idx   = (op == VC_SWAP) ? hit_idx : (any_free ? free_idx : oldest_idx);
    wr_addr  = fill_from_evict ? evict_addr  : disp_addr;
    wr_dirty = fill_from_evict ? evict_dirty : disp_dirty;
    wr_data  = fill_from_evict ? evict_data  : disp_data;
  end

  assign evict_oldest = (op == VC_FILL) && !any_free;
  assign wb_valid     = evict_oldest && entry_dirty[oldest_idx];
  assign wb_addr      = entry_tag[oldest_idx];
  assign wb_data      = entry_data[oldest_idx];

  vc_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_addr     (wr_addr),
    .wr_dirty    (wr_dirty),
    .wr_data     (wr_data),
    .clr_en      (clr_en),
    .clr_idx     (hit_idx),
    .entry_valid (entry_valid),
    .entry_tag   (entry_tag),
    .entry_dirty (entry_dirty),
    .entry_data  (entry_data)
  );

  vc_age #(.DEPTH(DEPTH)) u_age (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_valid (entry_valid),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .clr_en      (clr_en),
    .clr_idx     (hit_idx),
    .oldest_idx  (oldest_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_dirty  <= 1'b0;
      rsp_data   <= '0;
      fetch_addr <= '0;
    end else begin
      rsp_valid  <= probe_valid;
      rsp_hit    <= probe_valid && probe_hit;
      rsp_dirty  <= probe_valid && probe_hit && entry_dirty[hit_idx];
      rsp_data   <= (probe_valid && probe_hit) ? entry_data[hit_idx] : '0;
      fetch_addr <= probe_addr;
    end
  end

  assign fetch_valid = rsp_valid && !rsp_hit;

endmodule

// File: rtl/vc_checker.sv
`timescale 1ns/1ps
module vc_checker #(
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             probe_valid,
  input logic             disp_valid,
  input logic             evict_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             fetch_valid,
  input logic             wb_valid,
  input logic             evict_oldest,
  input logic [DEPTH-1:0] hit_vec,
  input logic [DEPTH-1:0] entry_valid
);

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (entry_valid == '0));

  assert_rsp_follows_probe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |=> rsp_valid);

  assert_no_rsp_without_probe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_valid |=> !rsp_valid);

  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_fetch_only_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (rsp_valid && !rsp_hit));

  assert_drop_frees_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && (|hit_vec) && !disp_valid) |=>
      ($countones(entry_valid) + 1 == $countones($past(entry_valid))));

  assert_wb_only_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (evict_oldest && (&entry_valid)));

  assert_wb_not_on_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((evict_valid && !probe_valid) || (probe_valid && disp_valid && !(|hit_vec))));

endmodule

bind victim_buf vc_checker #(.DEPTH(DEPTH)) u_vc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .probe_valid  (probe_valid),
  .disp_valid   (disp_valid),
  .evict_valid  (evict_valid),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .fetch_valid  (fetch_valid),
  .wb_valid     (wb_valid),
  .evict_oldest (evict_oldest),
  .hit_vec      (hit_vec),
  .entry_valid  (entry_valid)
);

// File: tb/tb_victim_buf.sv
`timescale 1ns/1ps
module tb_victim_buf;

  localparam int DEPTH  = 4;
  localparam int ADDR_W = 28;
  localparam int LINE_W = 64;

  typedef struct packed {
    logic [ADDR_W-1:0] a;
    logic              d;
    logic [LINE_W-1:0] data;
  } line_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evict_valid = 1'b0, probe_valid = 1'b0, disp_valid = 1'b0;
  logic evict_dirty = 1'b0, disp_dirty = 1'b0;
  logic [ADDR_W-1:0] evict_addr = '0, probe_addr = '0, disp_addr = '0;
  logic [LINE_W-1:0] evict_data = '0, disp_data = '0;
  logic rsp_valid, rsp_hit, rsp_dirty, fetch_valid, wb_valid;
  logic [LINE_W-1:0] rsp_data, wb_data;
  logic [ADDR_W-1:0] fetch_addr, wb_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int addr_ctr = 1;
  line_t mq[$];

  always #5 clk = ~clk;

  victim_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic line_t fresh(input bit dirty);
    line_t l;
    l.a    = {$urandom_range(4095, 0) , 16'(addr_ctr)};
    l.d    = dirty;
    l.data = {$urandom, $urandom};
    addr_ctr++;
    return l;
  endfunction

  function automatic int find_in_model(input logic [ADDR_W-1:0] a);
    for (int i = 0; i < mq.size(); i++) if (mq[i].a == a) return i;
    return -1;
  endfunction

  // Insertion into the reference: oldest leaves when full.
  function automatic bit model_insert(input line_t l, output line_t gone);
    bit wb = 0;
    gone = '0;
    if (mq.size() == DEPTH) begin
      gone = mq.pop_front();
      wb = gone.d;
    end
    mq.push_back(l);
    return wb;
  endfunction

  // One operation per cycle; called right after a falling edge.
  task automatic run_op(input string req, input bit do_probe, input logic [ADDR_W-1:0] paddr,
                        input bit do_disp, input line_t dl, input bit do_ev, input line_t el,
                        output bit was_hit);
    bit exp_hit = 0, exp_wb = 0;
    line_t hl = '0, gone = '0;
    int idx;
    if (do_probe) begin
      idx = find_in_model(paddr);
      if (idx >= 0) begin
        exp_hit = 1;
        hl = mq[idx];
        mq.delete(idx);
        if (do_disp) mq.push_back(dl);
      end else if (do_disp) begin
        exp_wb = model_insert(dl, gone);
      end
    end else if (do_ev) begin
      exp_wb = model_insert(el, gone);
    end
    was_hit = exp_hit;
    probe_valid = do_probe; probe_addr = paddr;
    disp_valid = do_disp; disp_addr = dl.a; disp_dirty = dl.d; disp_data = dl.data;
    evict_valid = do_ev; evict_addr = el.a; evict_dirty = el.d; evict_data = el.data;
    #1;
    chk(wb_valid == exp_wb, {req, "/R9"}, "wb_valid", LINE_W'(wb_valid), LINE_W'(exp_wb));
    if (exp_wb) begin
      chk(wb_addr == gone.a, {req, "/R8"}, "wb_addr", LINE_W'(wb_addr), LINE_W'(gone.a));
      chk(wb_data == gone.data, {req, "/R9"}, "wb_data", wb_data, gone.data);
    end
    @(negedge clk);
    chk(rsp_valid == do_probe, {req, "/R2"}, "rsp_valid", LINE_W'(rsp_valid), LINE_W'(do_probe));
    if (do_probe) begin
      chk(rsp_hit == exp_hit, {req, "/R3"}, "rsp_hit", LINE_W'(rsp_hit), LINE_W'(exp_hit));
      chk(fetch_valid == !exp_hit, {req, "/R4"}, "fetch_valid", LINE_W'(fetch_valid), LINE_W'(!exp_hit));
      if (exp_hit) begin
        chk(rsp_data == hl.data, {req, "/R3"}, "rsp_data", rsp_data, hl.data);
        chk(rsp_dirty == hl.d, {req, "/R3"}, "rsp_dirty", LINE_W'(rsp_dirty), LINE_W'(hl.d));
      end else begin
        chk(fetch_addr == paddr, {req, "/R4"}, "fetch_addr", LINE_W'(fetch_addr), LINE_W'(paddr));
      end
    end else begin
      chk(fetch_valid == 1'b0, {req, "/R2"}, "fetch_idle", LINE_W'(fetch_valid), '0);
    end
    probe_valid = 0; disp_valid = 0; evict_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    line_t n, l1, l2, l3, l4, x, e;
    bit h;
    void'($urandom(32'd2024));
    n = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 0 && fetch_valid == 0 && wb_valid == 0, "R1", "idle outputs",
        LINE_W'({rsp_valid, fetch_valid, wb_valid}), '0);

    run_op("R1", 1, 28'h0000123, 0, n, 0, n, h);
    chk(h == 0, "R1", "first probe miss", LINE_W'(h), '0);

    l1 = fresh(1); l2 = fresh(1); l3 = fresh(0); l4 = fresh(1);
    run_op("R7", 0, '0, 0, n, 1, l1, h);
    run_op("R7", 0, '0, 0, n, 1, l2, h);
    run_op("R7", 0, '0, 0, n, 1, l3, h);
    run_op("R7", 0, '0, 0, n, 1, l4, h);
    run_op("R7", 1, l3.a, 1, l3, 0, n, h);
    chk(h == 1, "R7", "stored line hits", LINE_W'(h), 1);

    run_op("R6", 1, l2.a, 0, n, 0, n, h);
    run_op("R6", 1, l2.a, 0, n, 0, n, h);
    chk(h == 0, "R6", "freed entry misses", LINE_W'(h), '0);

    run_op("R7", 0, '0, 0, n, 1, fresh(1), h);
    run_op("R8", 0, '0, 0, n, 1, fresh(0), h);
    run_op("R9", 0, '0, 0, n, 1, fresh(1), h);

    x = fresh(1);
    run_op("R5", 1, mq[1].a, 1, x, 0, n, h);
    chk(h == 1, "R5", "swap source hit", LINE_W'(h), 1);
    run_op("R5", 1, x.a, 1, x, 0, n, h);
    chk(h == 1, "R5", "swapped line hits", LINE_W'(h), 1);

    x = fresh(1);
    run_op("R12", 1, mq[0].a, 1, x, 0, n, h);
    run_op("R12", 0, '0, 0, n, 1, fresh(1), h);
    run_op("R12", 0, '0, 0, n, 1, fresh(1), h);
    run_op("R12", 0, '0, 0, n, 1, fresh(1), h);
    run_op("R12", 1, x.a, 0, n, 0, n, h);
    chk(h == 1, "R12", "swapped line outlives older", LINE_W'(h), 1);

    e = fresh(1);
    run_op("R10", 1, 28'h0fffff0, 0, n, 1, e, h);
    run_op("R10", 1, e.a, 0, n, 0, n, h);
    chk(h == 0, "R10", "insert during probe ignored", LINE_W'(h), '0);

    x = fresh(0);
    run_op("R11", 1, 28'h0ffff00, 1, x, 0, n, h);
    run_op("R11", 1, x.a, 1, x, 0, n, h);
    chk(h == 1, "R11", "displaced line kept on miss", LINE_W'(h), 1);

    for (int k = 0; k < 1500; k++) begin
      int sel = $urandom_range(99, 0);
      logic [ADDR_W-1:0] pa;
      if (sel < 40) begin
        run_op("R8", 0, '0, 0, n, 1, fresh($urandom_range(1, 0) == 1), h);
      end else begin
        if (mq.size() > 0 && $urandom_range(99, 0) < 60)
          pa = mq[$urandom_range(mq.size() - 1, 0)].a;
        else
          pa = fresh(0).a;
        run_op("R3", 1, pa, $urandom_range(99, 0) < 70, fresh($urandom_range(1, 0) == 1),
               sel > 95, fresh(1), h);
      end
    end

    finish_run();
  end

endmodule